// File: doc/BRIEF.md
# LCD Row Scan and Frame Timing Generator

This block sequences the common (row) side of a 100-row dot-matrix LCD. Each pulse of a line-rate enable advances it by one scan line. From the current line it derives the panel row being driven, as a one-hot select, and the display RAM row that feeds that panel row. It also produces a frame-start flag and the AC polarity signal that keeps the liquid crystal free of DC bias. For each 8-pixel column group it gives a flag that tells the column path to blank that group during the off half of the blink cycle.

The number of lines in a frame follows a two-bit duty code. The RAM row is offset by a scroll start line and wraps at the row count, so the picture can roll vertically. A partial mode shortens the frame to eight lines and places them anywhere on the panel. While partial mode is on, the other rows are never selected. The polarity toggles after a fixed run of 7, 11 or 13 lines, or once per frame. A 6-bit frame counter sets the blink rhythm: its top bit marks the blanked half of a 64-frame period.

Top module: `lcd_row_scan`

## Requirements
- R1: The frame length in lines is set by `duty_sel_i`: 00 gives 8 lines, 01 gives 64, 10 gives 80 and 11 gives 100. The line index counts 0..N-1 on `line_tick_i` and then wraps to 0. It does not move when `line_tick_i` is low.
- R2: `frame_start_o` is high exactly while the line index is 0.
- R3: `row_addr_o` equals (`start_line_i` + panel row) mod 100, where `start_line_i` < 100.
- R4: `row_sel_o` has exactly one bit set, at the current panel row. Outside partial mode the panel row equals the line index.
- R5: When `partial_en_i` is 1, the frame is 8 lines whatever `duty_sel_i` holds. The panel row is then (`partial_pos_i` + line index) mod 100, with `partial_pos_i` < 100.
- R6: `alt_sel_i` = 11, 10 and 01 toggle `pol_o` after every 13, 11 and 7 line ticks respectively.
- R7: `alt_sel_i` = 00 toggles `pol_o` once per frame, on the tick that wraps the line index.
- R8: A 6-bit frame counter advances at each frame wrap. While its top bit is 1 and `blink_en_i` is 1, `blink_off_o[g]` equals `blink_mask_i[g]` for every RAM row with `blink_top_i` ≤ `row_addr_o` ≤ `blink_bot_i`. Otherwise `blink_off_o[g]` is 0.
- R9: With `blink_en_i` = 0, `blink_off_o` is all zero in every frame and at every row.
- R10: After reset the line index is 0, `pol_o` is 0 and the frame counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_tick_i | input | 1 | One-cycle line advance enable |
| duty_sel_i | input | 2 | Frame length code |
| alt_sel_i | input | 2 | Polarity toggle period code |
| start_line_i | input | 7 | Scroll start RAM row |
| partial_en_i | input | 1 | Eight-line partial mode enable |
| partial_pos_i | input | 7 | First panel row of the partial window |
| blink_en_i | input | 1 | Blink enable |
| blink_top_i | input | 7 | First blinked RAM row, inclusive |
| blink_bot_i | input | 7 | Last blinked RAM row, inclusive |
| blink_mask_i | input | 20 | Blinked column groups |
| row_addr_o | output | 7 | RAM row of the current line |
| row_sel_o | output | 100 | One-hot panel row select |
| frame_start_o | output | 1 | High during the first line of a frame |
| pol_o | output | 1 | AC polarity |
| blink_off_o | output | 20 | Per-group blank flag |

## Verification
The bench sweeps every duty code through two full frames with a scroll start of 95. This setting makes the RAM row wrap partway through each frame, so an adder without the modulo step would show addresses of 100 or more, and a wrong frame length would move the frame-start line and the per-frame polarity. Each line-count polarity mode runs long enough to toggle several times, so an off-by-one in the period shows as an early or late flip. Partial mode places its window at row 96 so the window wraps past the last panel row, and it sets a full-duty code that the block must ignore. The blink run crosses frame 32 and frame 64, where a counter that used the wrong bit or did not wrap would blank in the wrong frames. It also checks both ends of the inclusive row range, where a strict comparison would drop the end rows.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_8   = 2'b00,
    DUTY_64  = 2'b01,
    DUTY_80  = 2'b10,
    DUTY_100 = 2'b11
  } duty_e;

  typedef enum logic [1:0] {
    ALT_FRAME = 2'b00,
    ALT_7     = 2'b01,
    ALT_11    = 2'b10,
    ALT_13    = 2'b11
  } alt_e;

  function automatic int duty_lines(logic [1:0] sel);
    case (duty_e'(sel))
      DUTY_8:   return 8;
      DUTY_64:  return 64;
      DUTY_80:  return 80;
      default:  return 100;
    endcase
  endfunction

  // 0 means: toggle once per frame
  function automatic int alt_len(logic [1:0] sel);
    case (alt_e'(sel))
      ALT_7:    return 7;
      ALT_11:   return 11;
      ALT_13:   return 13;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
  import lcd_scan_pkg::*;
#(
  parameter int ROWS       = 100,
  parameter int PART_LINES = 8,
  parameter int FRM_W      = 6,
  localparam int AW        = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       duty_sel_i,
  input  logic             partial_en_i,
  output logic [AW-1:0]    line_o,
  output logic             frame_end_o,
  output logic [FRM_W-1:0] frm_o
);

  logic [AW-1:0]    line_q;
  logic [FRM_W-1:0] frm_q;
  int               n_lines;

  assign n_lines     = partial_en_i ? PART_LINES : duty_lines(duty_sel_i);
  // >= covers a duty shortened mid-frame
  assign frame_end_o = tick_i && (int'(line_q) >= n_lines - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      frm_q  <= '0;
    end else if (tick_i) begin
      if (frame_end_o) begin
        line_q <= '0;
        frm_q  <= frm_q + FRM_W'(1);
      end else begin
        line_q <= line_q + AW'(1);
      end
    end
  end

  assign line_o = line_q;
  assign frm_o  = frm_q;

endmodule

// File: rtl/lcd_pol_gen.sv
module lcd_pol_gen
  import lcd_scan_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       frame_end_i,
  input  logic [1:0] alt_sel_i,
  output logic       pol_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             pol_q;
  int               run_len;

  assign run_len = alt_len(alt_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (tick_i) begin
      if (run_len == 0) begin
        cnt_q <= '0;
        if (frame_end_i) pol_q <= ~pol_q;
      end else if (int'(cnt_q) >= run_len - 1) begin
        cnt_q <= '0;
        pol_q <= ~pol_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pol_o = pol_q;

endmodule

// File: rtl/lcd_row_map.sv
module lcd_row_map #(
  parameter int ROWS = 100,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic [AW-1:0] line_i,
  input  logic          partial_en_i,
  input  logic [AW-1:0] partial_pos_i,
  input  logic [AW-1:0] start_line_i,
  output logic [AW-1:0] row_addr_o,
  output logic [ROWS-1:0] row_sel_o
);

  logic [AW:0]   pane_sum, addr_sum;
  logic [AW-1:0] pane_row;

  assign pane_sum = partial_en_i ? ({1'b0, partial_pos_i} + {1'b0, line_i})
                                 : {1'b0, line_i};
  assign pane_row = (pane_sum >= (AW+1)'(ROWS)) ? AW'(pane_sum - (AW+1)'(ROWS))
                                                : AW'(pane_sum);

  assign addr_sum   = {1'b0, start_line_i} + {1'b0, pane_row};
  assign row_addr_o = (addr_sum >= (AW+1)'(ROWS)) ? AW'(addr_sum - (AW+1)'(ROWS))
                                                  : AW'(addr_sum);

  for (genvar r = 0; r < ROWS; r++) begin : g_sel
    assign row_sel_o[r] = (pane_row == AW'(r));
  end

endmodule

// File: rtl/lcd_blink_gate.sv
module lcd_blink_gate #(
  parameter int ROWS   = 100,
  parameter int GROUPS = 20,
  localparam int AW    = $clog2(ROWS)
) (
  input  logic              blink_en_i,
  input  logic              phase_i,
  input  logic [AW-1:0]     row_addr_i,
  input  logic [AW-1:0]     top_i,
  input  logic [AW-1:0]     bot_i,
  input  logic [GROUPS-1:0] mask_i,
  output logic [GROUPS-1:0] off_o
);

  logic in_band;

  assign in_band = (row_addr_i >= top_i) && (row_addr_i <= bot_i);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign off_o[g] = blink_en_i && phase_i && in_band && mask_i[g];
  end

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int ROWS       = 100,
  parameter int GROUPS     = 20,
  parameter int PART_LINES = 8,
  parameter int FRM_W      = 6,
  parameter int CNT_W      = 4,
  localparam int AW        = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_tick_i,
  input  logic [1:0]        duty_sel_i,
  input  logic [1:0]        alt_sel_i,
  input  logic [AW-1:0]     start_line_i,
  input  logic              partial_en_i,
  input  logic [AW-1:0]     partial_pos_i,
  input  logic              blink_en_i,
  input  logic [AW-1:0]     blink_top_i,
  input  logic [AW-1:0]     blink_bot_i,
  input  logic [GROUPS-1:0] blink_mask_i,
  output logic [AW-1:0]     row_addr_o,
  output logic [ROWS-1:0]   row_sel_o,
  output logic              frame_start_o,
  output logic              pol_o,
  output logic [GROUPS-1:0] blink_off_o
);

  logic [AW-1:0]    line;
  logic             frame_end;
  logic [FRM_W-1:0] frm;

  lcd_line_ctr #(
    .ROWS(ROWS), .PART_LINES(PART_LINES), .FRM_W(FRM_W)
  ) i_line_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (line_tick_i),
    .duty_sel_i   (duty_sel_i),
    .partial_en_i (partial_en_i),
    .line_o       (line),
    .frame_end_o  (frame_end),
    .frm_o        (frm)
  );

  lcd_pol_gen #(.CNT_W(CNT_W)) i_pol_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (line_tick_i),
    .frame_end_i (frame_end),
    .alt_sel_i   (alt_sel_i),
    .pol_o       (pol_o)
  );

  lcd_row_map #(.ROWS(ROWS)) i_row_map (
    .line_i        (line),
    .partial_en_i  (partial_en_i),
    .partial_pos_i (partial_pos_i),
    .start_line_i  (start_line_i),
    .row_addr_o    (row_addr_o),
    .row_sel_o     (row_sel_o)
  );

  lcd_blink_gate #(.ROWS(ROWS), .GROUPS(GROUPS)) i_blink_gate (
    .blink_en_i (blink_en_i),
    .phase_i    (frm[FRM_W-1]),
    .row_addr_i (row_addr_o),
    .top_i      (blink_top_i),
    .bot_i      (blink_bot_i),
    .mask_i     (blink_mask_i),
    .off_o      (blink_off_o)
  );

  assign frame_start_o = (line == '0);

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int ROWS   = 100,
  parameter int GROUPS = 20,
  localparam int AW    = $clog2(ROWS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_tick_i,
  input logic [AW-1:0]     start_line_i,
  input logic              partial_en_i,
  input logic [AW-1:0]     partial_pos_i,
  input logic              blink_en_i,
  input logic [AW-1:0]     row_addr_o,
  input logic [ROWS-1:0]   row_sel_o,
  input logic              frame_start_o,
  input logic              pol_o,
  input logic [GROUPS-1:0] blink_off_o
);

  a_r4_one_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_sel_o) == 1);

  a_r1_hold_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(frame_start_o));

  a_r6_pol_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(pol_o));

  a_r3_frame_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !partial_en_i && start_line_i < AW'(ROWS))
      |-> row_addr_o == start_line_i);

  a_r5_window_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && partial_en_i && partial_pos_i < AW'(ROWS))
      |-> (row_sel_o >> partial_pos_i) & ROWS'(1) == ROWS'(1));

  a_r9_no_blink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blink_en_i |-> blink_off_o == '0);

  a_r3_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_addr_o < AW'(ROWS));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(.ROWS(ROWS), .GROUPS(GROUPS)) i_lcd_row_scan_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_tick_i   (line_tick_i),
  .start_line_i  (start_line_i),
  .partial_en_i  (partial_en_i),
  .partial_pos_i (partial_pos_i),
  .blink_en_i    (blink_en_i),
  .row_addr_o    (row_addr_o),
  .row_sel_o     (row_sel_o),
  .frame_start_o (frame_start_o),
  .pol_o         (pol_o),
  .blink_off_o   (blink_off_o)
);

// File: tb/test_lcd_row_scan.sv
module test_lcd_row_scan;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_tick_i = 1'b0;
  logic [1:0]  duty_sel_i = 2'b00;
  logic [1:0]  alt_sel_i = 2'b00;
  logic [6:0]  start_line_i = '0;
  logic        partial_en_i = 1'b0;
  logic [6:0]  partial_pos_i = '0;
  logic        blink_en_i = 1'b0;
  logic [6:0]  blink_top_i = '0;
  logic [6:0]  blink_bot_i = '0;
  logic [19:0] blink_mask_i = '0;
  logic [6:0]  row_addr_o;
  logic [99:0] row_sel_o;
  logic        frame_start_o;
  logic        pol_o;
  logic [19:0] blink_off_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  lcd_row_scan i_lcd_row_scan (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic tick();
    line_tick_i = 1'b1;
    @(negedge clk_i);
    line_tick_i = 1'b0;
  endtask

  function automatic int dl(int s);
    return (s == 0) ? 8 : (s == 1) ? 64 : (s == 2) ? 80 : 100;
  endfunction

  initial begin
    do_reset();
    // R10 reset state
    check("R10 addr", 128'(row_addr_o), 128'(0));
    check("R10 fs", 128'(frame_start_o), 128'(1));
    check("R10 pol", 128'(pol_o), 128'(0));
    // R1 no advance without tick
    repeat (5) @(negedge clk_i);
    check("R1 hold", 128'(row_sel_o), 128'(1));

    // R1 R2 R3 R4 R7: duty sweep, scroll wrap, frame polarity
    for (int s = 0; s < 4; s++) begin
      duty_sel_i = 2'(s);
      alt_sel_i = 2'b00;
      start_line_i = 7'd95;
      do_reset();
      for (int t = 1; t <= 2 * dl(s) + 1; t++) begin
        int ln;
        tick();
        ln = t % dl(s);
        check("R3 addr", 128'(row_addr_o), 128'((95 + ln) % 100));
        check("R4 sel", 128'(row_sel_o), 128'(1) << ln);
        check("R2 fs", 128'(frame_start_o), 128'(ln == 0));
        check("R7 pol", 128'(pol_o), 128'((t / dl(s)) % 2));
      end
    end

    // R6 line-count polarity
    for (int a = 1; a < 4; a++) begin
      int k;
      k = (a == 1) ? 7 : (a == 2) ? 11 : 13;
      duty_sel_i = 2'b11;
      alt_sel_i = 2'(a);
      start_line_i = '0;
      do_reset();
      for (int t = 1; t <= 60; t++) begin
        tick();
        check("R6 pol", 128'(pol_o), 128'((t / k) % 2));
      end
    end

    // R5 partial window wraps, duty code ignored
    duty_sel_i = 2'b11;
    alt_sel_i = 2'b00;
    partial_en_i = 1'b1;
    partial_pos_i = 7'd96;
    start_line_i = 7'd10;
    do_reset();
    for (int t = 1; t <= 20; t++) begin
      int ph;
      tick();
      ph = (96 + t % 8) % 100;
      check("R5 sel", 128'(row_sel_o), 128'(1) << ph);
      check("R5 addr", 128'(row_addr_o), 128'((10 + ph) % 100));
      check("R5 fs", 128'(frame_start_o), 128'(t % 8 == 0));
      check("R7 pol partial", 128'(pol_o), 128'((t / 8) % 2));
    end
    partial_en_i = 1'b0;

    // R8 blink phase, inclusive band, mask
    duty_sel_i = 2'b00;
    start_line_i = '0;
    blink_en_i = 1'b1;
    blink_top_i = 7'd2;
    blink_bot_i = 7'd5;
    blink_mask_i = 20'hA5C3F;
    do_reset();
    for (int t = 1; t <= 8 * 70; t++) begin
      int ln, fr;
      bit on;
      tick();
      ln = t % 8;
      fr = (t / 8) % 64;
      on = (fr >= 32) && (ln >= 2) && (ln <= 5);
      check("R8 blink", 128'(blink_off_o), on ? 128'(blink_mask_i) : 128'(0));
    end

    // R9 blink disabled
    blink_en_i = 1'b0;
    do_reset();
    for (int t = 1; t <= 8 * 40; t++) begin
      tick();
      check("R9 off", 128'(blink_off_o), 128'(0));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule